// File: doc/BRIEF.md
# Idle Wake-Up Timer

The block is a free-running 13-bit counter advanced once per instruction clock. Each change of its most significant bit, in either direction, marks the end of a wake interval of 4096 cycles. On that cycle the block pulses a one-cycle strobe toward the power sequencer, which uses it to bring the core out of its low-power idle state. The same event is latched into a sticky pending flag that software later clears.

A separate enable bit decides whether a latched pending flag is also presented to the core as an interrupt request. The wake strobe does not depend on that bit. With the enable set, the core services the interrupt before resuming. With it cleared, the core simply resumes. Both bits are written by software through single-cycle write strobes with a data bit.

Top module: `idle_wake_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the pending flag and the enable bit. While reset is held, and in the first cycle after it, the outputs pend_o, en_o, irq_o and wake_o are all 0.
- R2: wake_o is high for exactly one cycle each time counter bit 12 changes value. With reset released after edge 0, that happens when the counter reaches 4096 (rising) and when it wraps from 8191 to 0 (falling). So it occurs in cycles 4096·n after reset, for n ≥ 1, and at no other time.
- R3: The pending flag pend_o becomes 1 on the cycle after a wake_o strobe. It then stays 1 until software clears it.
- R4: A one-cycle pnd_wr_i with pnd_wdata_i = 0 clears pend_o on the next cycle. With pnd_wdata_i = 1 it sets pend_o.
- R5: If a software clear of the pending flag falls in the same cycle as a wake_o strobe, the flag ends up set.
- R6: irq_o is 1 exactly when both pend_o and en_o are 1. Clearing the enable withdraws a request at once, without touching pend_o.
- R7: The wake strobe and the pending flag behave the same whether the enable bit is 0 or 1.
- R8: en_o takes the value of en_wdata_i on the cycle after a one-cycle en_wr_i. It does not change at any other time. Enable writes have no effect on pend_o or wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous reset, active high |
| pnd_wr_i | input | 1 | Write strobe for the pending flag |
| pnd_wdata_i | input | 1 | Value written to the pending flag |
| en_wr_i | input | 1 | Write strobe for the interrupt enable |
| en_wdata_i | input | 1 | Value written to the interrupt enable |
| pend_o | output | 1 | Sticky pending flag |
| en_o | output | 1 | Current interrupt enable |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle wake strobe to the power sequencer |

## Verification
The bench compares wake_o against its own cycle count across both the rising and the falling change of the top counter bit. A design that only woke on the rising change would show a period of 8192, and one that woke on a terminal count would be off by its decode delay. It lands a software clear exactly on a strobe cycle, where a clear-wins priority would lose the event. It also toggles the enable around a held pending flag, which catches an enable that gates the flag itself or the wake strobe rather than only the request. A reset in the middle of a run checks that the counter restarts rather than continuing its old phase.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

    localparam int unsigned DEF_CNT_W   = 13;
    localparam int unsigned DEF_TAP_BIT = 12;

    // One software write port: strobe plus data bit
    typedef struct packed {
        logic wr;
        logic data;
    } sw_wr_t;

    // Flag state held by the block
    typedef struct packed {
        logic pend;
        logic en;
    } flag_state_t;

    // Next value of a sticky flag: a hardware set outranks a software write
    function automatic logic sticky_next(input logic cur, input logic hw_set,
                                         input sw_wr_t wr);
        logic nxt;
        nxt = cur;
        if (hw_set)
            nxt = 1'b1;
        else if (wr.wr)
            nxt = wr.data;
        return nxt;
    endfunction

    // Next value of a plain software bit
    function automatic logic soft_next(input logic cur, input sw_wr_t wr);
        return wr.wr ? wr.data : cur;
    endfunction

endpackage

// File: rtl/idle_wake_counter.sv
module idle_wake_counter
    import idle_wake_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned TAP_BIT = DEF_TAP_BIT
) (
    input  logic clk,
    input  logic rst,
    output logic tap_event_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             tap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tap_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
            tap_q <= cnt_q[TAP_BIT];
        end
    end

    // Any change of the tapped bit, up or down, is an event
    assign tap_event_o = cnt_q[TAP_BIT] ^ tap_q;

endmodule

// File: rtl/idle_wake_flags.sv
module idle_wake_flags
    import idle_wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hw_set_i,
    input  sw_wr_t      pnd_wr_i,
    input  sw_wr_t      en_wr_i,
    output flag_state_t state_o
);

    flag_state_t st_q;
    flag_state_t st_d;

    always_comb begin
        st_d.pend = sticky_next(st_q.pend, hw_set_i, pnd_wr_i);
        st_d.en   = soft_next(st_q.en, en_wr_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer
    import idle_wake_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned TAP_BIT = DEF_TAP_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic pnd_wr_i,
    input  logic pnd_wdata_i,
    input  logic en_wr_i,
    input  logic en_wdata_i,
    output logic pend_o,
    output logic en_o,
    output logic irq_o,
    output logic wake_o
);

    sw_wr_t      pnd_wr;
    sw_wr_t      en_wr;
    flag_state_t flags;
    logic        tap_event;

    assign pnd_wr = '{wr: pnd_wr_i, data: pnd_wdata_i};
    assign en_wr  = '{wr: en_wr_i,  data: en_wdata_i};

    idle_wake_counter #(
        .CNT_W   (CNT_W),
        .TAP_BIT (TAP_BIT)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tap_event_o (tap_event)
    );

    idle_wake_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .hw_set_i (tap_event),
        .pnd_wr_i (pnd_wr),
        .en_wr_i  (en_wr),
        .state_o  (flags)
    );

    assign wake_o = tap_event;
    assign pend_o = flags.pend;
    assign en_o   = flags.en;
    assign irq_o  = flags.pend & flags.en;

endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk #(
    parameter int unsigned TAP_BIT = 12
) (
    input logic clk,
    input logic rst,
    input logic pnd_wr_i,
    input logic pnd_wdata_i,
    input logic en_wr_i,
    input logic en_wdata_i,
    input logic pend_o,
    input logic en_o,
    input logic irq_o,
    input logic wake_o
);

    localparam int unsigned GAP_W  = TAP_BIT + 2;
    localparam logic [GAP_W-1:0] PERIOD = GAP_W'(1) << TAP_BIT;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= '0;
        else if (wake_o)
            gap_q <= GAP_W'(1);
        else if (gap_q != '1)
            gap_q <= gap_q + GAP_W'(1);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pend_o && !en_o && !irq_o && !wake_o));

    assert_wake_period_R2: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (gap_q == PERIOD));

    assert_wake_single_R2: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);

    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !(pnd_wr_i && !pnd_wdata_i)) |=> pend_o);

    assert_pend_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(wake_o || (pnd_wr_i && pnd_wdata_i)));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> pend_o);

    assert_irq_withdraw_R6: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && !en_wdata_i) |=> !irq_o);

    assert_en_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !en_wr_i |=> $stable(en_o));

endmodule

bind idle_wake_timer idle_wake_chk #(.TAP_BIT(TAP_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pnd_wr_i    (pnd_wr_i),
    .pnd_wdata_i (pnd_wdata_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .pend_o      (pend_o),
    .en_o        (en_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/tb_idle_wake_timer.sv
module tb_idle_wake_timer;

    localparam time CLK_P    = 10ns;
    localparam int  PERIOD   = 4096;
    localparam int  WATCHDOG = 200000;

    typedef struct packed {
        logic [15:0] gap;
        logic        pw;
        logic        pd;
        logic        ew;
        logic        ed;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{gap: 16'd10,   pw: 1'b0, pd: 1'b0, ew: 1'b1, ed: 1'b1},
        '{gap: 16'd4100, pw: 1'b0, pd: 1'b0, ew: 1'b0, ed: 1'b0},
        '{gap: 16'd5,    pw: 1'b1, pd: 1'b0, ew: 1'b0, ed: 1'b0},
        '{gap: 16'd4090, pw: 1'b0, pd: 1'b0, ew: 1'b1, ed: 1'b0},
        '{gap: 16'd3,    pw: 1'b1, pd: 1'b1, ew: 1'b0, ed: 1'b0},
        '{gap: 16'd3,    pw: 1'b1, pd: 1'b0, ew: 1'b0, ed: 1'b0},
        '{gap: 16'd3,    pw: 1'b1, pd: 1'b1, ew: 1'b0, ed: 1'b0},
        '{gap: 16'd3,    pw: 1'b0, pd: 1'b0, ew: 1'b1, ed: 1'b1},
        '{gap: 16'd4200, pw: 1'b1, pd: 1'b0, ew: 1'b0, ed: 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pnd_wr_i = 1'b0, pnd_wdata_i = 1'b0;
    logic en_wr_i = 1'b0, en_wdata_i = 1'b0;
    logic pend_o, en_o, irq_o, wake_o;

    int   n_chk = 0;
    int   n_bad = 0;
    int   m_k = 0;
    logic m_pend = 1'b0, m_en = 1'b0, m_wake = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    idle_wake_timer dut (
        .clk         (clk),
        .rst         (rst),
        .pnd_wr_i    (pnd_wr_i),
        .pnd_wdata_i (pnd_wdata_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .pend_o      (pend_o),
        .en_o        (en_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                     req, what, m_k, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic tick(input logic r, input logic pw, input logic pd,
                        input logic ew, input logic ed);
        rst = r; pnd_wr_i = pw; pnd_wdata_i = pd; en_wr_i = ew; en_wdata_i = ed;
        @(posedge clk);
        if (r) begin
            m_k = 0; m_pend = 1'b0; m_en = 1'b0;
        end else begin
            if (m_wake)  m_pend = 1'b1;     // R5: set wins
            else if (pw) m_pend = pd;       // R4
            if (ew)      m_en = ed;         // R8
            m_k++;
        end
        m_wake = (m_k != 0) && (m_k % PERIOD == 0);   // R2
        @(negedge clk);
        pnd_wr_i = 1'b0; en_wr_i = 1'b0;
        check(r ? "R1" : "R2", "wake_o", wake_o, m_wake);
        check(r ? "R1" : "R3", "pend_o", pend_o, m_pend);
        check(r ? "R1" : "R8", "en_o",   en_o,   m_en);
        check(r ? "R1" : "R6", "irq_o",  irq_o,  m_pend & m_en);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_to_wake();
        while (!m_wake) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);   // R1: writes during reset ignored
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", "pend_o after reset", pend_o, 1'b0);
        check("R1", "en_o after reset",   en_o,   1'b0);

        // Vector table: R2 rising and falling bit changes, R3, R4, R6, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            tick(1'b0, VECS[v].pw, VECS[v].pd, VECS[v].ew, VECS[v].ed);
            idle(int'(VECS[v].gap));
        end

        // R5: clear lands on the strobe cycle, set must win
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5", "pend_o cleared before strobe", pend_o, 1'b0);
        run_to_wake();
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5", "pend_o after clear on strobe", pend_o, 1'b1);

        // R6: disabling withdraws irq at once while pend stays
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6", "irq_o after disable", irq_o, 1'b0);
        check("R6", "pend_o kept after disable", pend_o, 1'b1);

        // R7: strobe with enable off, then enable write on the strobe cycle
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_to_wake();
        check("R7", "wake_o with enable off", wake_o, 1'b1);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R7", "pend_o set with enable written", pend_o, 1'b1);
        check("R6", "irq_o raised", irq_o, 1'b1);

        // R1: reset mid-run restarts the counter phase
        idle(1000);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(PERIOD + 5);
        check("R1", "pend_o after restart period", pend_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * WATCHDOG);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule